// File: doc/BRIEF.md
# Branch Target Cache Predictor

This block guesses, at fetch time, whether a branch will be taken and where it goes. A direct-mapped table, indexed by word-address bits of the branch and tagged with the remaining upper bits, holds a valid flag, a 2-bit saturating confidence counter and the last taken target. When the table has no matching entry, the guess comes from the offset's sign: a backward branch is guessed taken and a forward branch is guessed not taken. The block also adds the decoded offset to the branch address to form the target, and supplies the return address used when the branch links.

Each accepted lookup records the path that was not chosen in a small in-order queue. When the pipeline reports the real outcome of the oldest pending branch, the block trains the table. If the guess was wrong, it emits a one-cycle redirect that carries the recorded alternative address. Lookups enter on a valid/ready handshake. A lookup is accepted only when the output register is free or being drained and the pending queue has room. The prediction output is held stable while its consumer holds ready low. Resolves enter on a valid/ready handshake whose ready is high whenever at least one prediction is pending. The redirect is a plain pulse with no back-pressure.

Top module: `btc_predictor`

## Requirements
- R1: After reset, pr_valid, rd_valid and rs_ready are 0, lk_ready is 1, and every table entry is invalid, so the first lookup of any address reports pr_hit = 0.
- R2: On a lookup that misses the table (pr_hit = 0), pr_taken equals bit 23 of lk_offset: a negative offset predicts taken and a positive one predicts not taken.
- R3: On a miss, pr_target = lk_pc + 8 + (sign-extended lk_offset shifted left by 2), modulo 2^32, which gives a reach of plus or minus 32 MB. pr_link_addr = lk_pc + 4 and pr_link_wr = lk_link.
- R4: pr_alt is the path not predicted. It is pr_link_addr when pr_taken = 1 and pr_target when pr_taken = 0.
- R5: A resolve whose address misses the table allocates an entry only when rs_taken = 1, with counter value 2 and target rs_target. A not-taken miss leaves the table unchanged.
- R6: A hitting lookup predicts taken when its counter is 2 or 3 and reports the stored target. Each resolve that hits moves the counter up by one on taken and down by one on not taken, saturating at 0 and 3. A taken resolve also refreshes the stored target.
- R7: The table index is lk_pc bits [IDX_W+1:2]. A taken resolve of a different address with the same index replaces the resident entry. A not-taken one does not replace it.
- R8: One cycle after an accepted resolve, rd_valid is 1 exactly when rs_taken differs from the oldest pending prediction. rd_addr then holds that prediction's pr_alt.
- R9: While pr_valid = 1 and pr_ready = 0, the prediction outputs hold their values and lk_ready is 0. pr_valid falls one cycle after pr_ready is seen high, unless a new lookup is accepted in that cycle.
- R10: rs_ready is 1 exactly when at least one prediction is pending. Resolves are matched to lookups in acceptance order. A resolve presented while rs_ready = 0 has no effect on the table or the redirect.
- R11: At most PEND_DEPTH predictions are pending. When that many are pending, lk_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle when high with lk_valid |
| lk_pc | input | 32 | Address of the branch being fetched |
| lk_offset | input | 24 | Decoded word offset field of the branch |
| lk_link | input | 1 | Branch writes the return address |
| pr_valid | output | 1 | Prediction valid |
| pr_ready | input | 1 | Consumer takes the prediction |
| pr_taken | output | 1 | Predicted direction |
| pr_hit | output | 1 | Prediction came from a table entry |
| pr_target | output | 32 | Branch target (stored on hit, computed on miss) |
| pr_alt | output | 32 | Address of the path not predicted |
| pr_link_wr | output | 1 | Return address is to be written |
| pr_link_addr | output | 32 | Return address, the branch address plus 4 |
| rs_valid | input | 1 | Resolve valid |
| rs_ready | output | 1 | Resolve accepted when high with rs_valid |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | 32 | Actual target, word aligned |
| rd_valid | output | 1 | Misprediction redirect pulse |
| rd_addr | output | 32 | Redirect fetch address |

## Verification
The bench builds the block with IDX_W = 4, which gives a 16-entry table, and PEND_DEPTH = 2. With a 16-entry table, two branch addresses 64 bytes apart share an index, so the replacement and no-replacement cases of R7 can be reached with a handful of addresses. With a queue depth of 2, two lookups fill the queue, which exposes the full-queue stall and the in-order pairing of resolves with their saved alternatives. The offset width stays at 24, so the extreme forward and backward offsets exercise the full plus or minus 32 MB reach.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int unsigned ADDR_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic  taken;
    addr_t alt;
  } pend_t;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/btc_target_calc.sv
module btc_target_calc #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFS_W = 24
) (
  input  logic [AW-1:0]    pc,
  input  logic [OFS_W-1:0] ofs,
  output logic [AW-1:0]    tgt,
  output logic [AW-1:0]    seq
);
  localparam int unsigned SH_W = OFS_W + 2;
  localparam int unsigned EXT_W = AW - SH_W;

  logic [AW-1:0] disp;

  assign disp = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
  assign tgt  = pc + AW'(8) + disp;
  assign seq  = pc + AW'(4);
endmodule

// File: rtl/btc_table.sv
module btc_table #(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned TAG_W = 23,
  parameter int unsigned TW    = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_vld,
  output logic [TAG_W-1:0] a_tag,
  output logic [1:0]       a_ctr,
  output logic [TW-1:0]    a_tgt,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_vld,
  output logic [TAG_W-1:0] b_tag,
  output logic [1:0]       b_ctr,
  output logic [TW-1:0]    b_tgt,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [1:0]       w_ctr,
  input  logic [TW-1:0]    w_tgt
);
  localparam int unsigned N = 1 << IDX_W;

  logic             vld_q [N];
  logic [TAG_W-1:0] tag_q [N];
  logic [1:0]       ctr_q [N];
  logic [TW-1:0]    tgt_q [N];

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic sel;
    assign sel = we && (w_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[e] <= 1'b0;
      else if (sel) vld_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e] <= w_tag;
        ctr_q[e] <= w_ctr;
        tgt_q[e] <= w_tgt;
      end
    end
  end

  assign a_vld = vld_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign a_ctr = ctr_q[a_idx];
  assign a_tgt = tgt_q[a_idx];
  assign b_vld = vld_q[b_idx];
  assign b_tag = tag_q[b_idx];
  assign b_ctr = ctr_q[b_idx];
  assign b_tgt = tgt_q[b_idx];
endmodule

// File: rtl/btc_pend_fifo.sv
module btc_pend_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 33,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/btc_predictor.sv
module btc_predictor #(
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned OFS_W      = 24,
  parameter int unsigned PEND_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_pc,
  input  logic [23:0] lk_offset,
  input  logic        lk_link,
  output logic        pr_valid,
  input  logic        pr_ready,
  output logic        pr_taken,
  output logic        pr_hit,
  output logic [31:0] pr_target,
  output logic [31:0] pr_alt,
  output logic        pr_link_wr,
  output logic [31:0] pr_link_addr,
  input  logic        rs_valid,
  output logic        rs_ready,
  input  logic [31:0] rs_pc,
  input  logic        rs_taken,
  input  logic [31:0] rs_target,
  output logic        rd_valid,
  output logic [31:0] rd_addr
);
  import btc_pkg::*;

  localparam int unsigned TAG_W = ADDR_W - IDX_W - 2;
  localparam int unsigned TW    = ADDR_W - 2;
  localparam int unsigned PEW   = $bits(pend_t);
  localparam int unsigned CNT_W = $clog2(PEND_DEPTH + 1);

  // lookup side
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             t_vld;
  logic [TAG_W-1:0] t_tag;
  logic [1:0]       t_ctr;
  logic [TW-1:0]    t_tgt;
  addr_t            calc_tgt, calc_seq;
  logic             lk_hit, lk_pred;
  addr_t            lk_tgt_sel, lk_alt;
  logic             lk_fire;

  // resolve side
  logic [IDX_W-1:0] rs_idx;
  logic [TAG_W-1:0] rs_tag;
  logic             r_vld;
  logic [TAG_W-1:0] r_tag;
  logic [1:0]       r_ctr;
  logic [TW-1:0]    r_tgt;
  logic             rs_hit, rs_fire;
  logic             w_en;
  logic [1:0]       w_ctr;
  logic [TW-1:0]    w_tgt;

  // pending queue
  pend_t            pend_in, pend_head;
  logic [PEW-1:0]   pend_head_raw;
  logic [CNT_W-1:0] pend_cnt;
  logic             pend_full, pend_empty;

  assign lk_idx = lk_pc[IDX_W+1:2];
  assign lk_tag = lk_pc[ADDR_W-1:IDX_W+2];
  assign rs_idx = rs_pc[IDX_W+1:2];
  assign rs_tag = rs_pc[ADDR_W-1:IDX_W+2];

  btc_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TW(TW)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .a_idx (lk_idx),
    .a_vld (t_vld),
    .a_tag (t_tag),
    .a_ctr (t_ctr),
    .a_tgt (t_tgt),
    .b_idx (rs_idx),
    .b_vld (r_vld),
    .b_tag (r_tag),
    .b_ctr (r_ctr),
    .b_tgt (r_tgt),
    .we    (w_en),
    .w_idx (rs_idx),
    .w_tag (rs_tag),
    .w_ctr (w_ctr),
    .w_tgt (w_tgt)
  );

  btc_target_calc #(.AW(ADDR_W), .OFS_W(OFS_W)) u_calc (
    .pc  (lk_pc),
    .ofs (lk_offset[OFS_W-1:0]),
    .tgt (calc_tgt),
    .seq (calc_seq)
  );

  // prediction select
  assign lk_hit     = t_vld && (t_tag == lk_tag);
  assign lk_pred    = lk_hit ? t_ctr[1] : lk_offset[OFS_W-1];
  assign lk_tgt_sel = lk_hit ? {t_tgt, 2'b00} : calc_tgt;
  assign lk_alt     = lk_pred ? calc_seq : lk_tgt_sel;

  assign lk_ready = (!pr_valid || pr_ready) && !pend_full;
  assign lk_fire  = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_valid     <= 1'b0;
      pr_taken     <= 1'b0;
      pr_hit       <= 1'b0;
      pr_target    <= '0;
      pr_alt       <= '0;
      pr_link_wr   <= 1'b0;
      pr_link_addr <= '0;
    end else if (lk_fire) begin
      pr_valid     <= 1'b1;
      pr_taken     <= lk_pred;
      pr_hit       <= lk_hit;
      pr_target    <= lk_tgt_sel;
      pr_alt       <= lk_alt;
      pr_link_wr   <= lk_link;
      pr_link_addr <= calc_seq;
    end else if (pr_ready) begin
      pr_valid <= 1'b0;
    end
  end

  assign pend_in = '{taken: lk_pred, alt: lk_alt};

  btc_pend_fifo #(.DEPTH(PEND_DEPTH), .W(PEW)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (lk_fire),
    .din   (pend_in),
    .pop   (rs_fire),
    .dout  (pend_head_raw),
    .cnt   (pend_cnt),
    .full  (pend_full),
    .empty (pend_empty)
  );

  assign pend_head = pend_t'(pend_head_raw);

  // resolve and training
  assign rs_ready = !pend_empty;
  assign rs_fire  = rs_valid && rs_ready;
  assign rs_hit   = r_vld && (r_tag == rs_tag);
  assign w_en     = rs_fire && (rs_hit || rs_taken);
  assign w_ctr    = rs_hit ? ctr_step(r_ctr, rs_taken) : 2'b10;
  assign w_tgt    = rs_taken ? rs_target[ADDR_W-1:2] : r_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
    end else begin
      rd_valid <= rs_fire && (rs_taken != pend_head.taken);
      if (rs_fire) rd_addr <= pend_head.alt;
    end
  end
endmodule

// File: rtl/btc_predictor_chk.sv
module btc_predictor_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_ready,
  input logic          pr_valid,
  input logic          pr_ready,
  input logic          pr_taken,
  input logic [31:0]   pr_target,
  input logic [31:0]   pr_alt,
  input logic [31:0]   pr_link_addr,
  input logic          rs_valid,
  input logic          rs_ready,
  input logic          rd_valid,
  input logic [CW-1:0] occ
);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_ready |=> pr_valid && $stable(pr_target) && $stable(pr_alt) && $stable(pr_taken));

  a_r9_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_ready |-> !lk_ready);

  a_r4_alt_seq: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && pr_taken |-> pr_alt == pr_link_addr);

  a_r4_alt_tgt: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_taken |-> pr_alt == pr_target);

  a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rs_valid && rs_ready));

  a_r11_cap: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  a_r11_full: assert property (@(posedge clk) disable iff (!rst_n)
    occ == CW'(DEPTH) |-> !lk_ready);
endmodule

bind btc_predictor btc_predictor_chk #(.DEPTH(PEND_DEPTH), .CW(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_ready     (lk_ready),
  .pr_valid     (pr_valid),
  .pr_ready     (pr_ready),
  .pr_taken     (pr_taken),
  .pr_target    (pr_target),
  .pr_alt       (pr_alt),
  .pr_link_addr (pr_link_addr),
  .rs_valid     (rs_valid),
  .rs_ready     (rs_ready),
  .rd_valid     (rd_valid),
  .occ          (pend_cnt)
);

// File: tb/btc_predictor_tb.sv
`timescale 1ns/100ps
module btc_predictor_tb;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned DEPTH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_link = 1'b0, pr_ready = 1'b1;
  logic [31:0] lk_pc = '0;
  logic [23:0] lk_offset = '0;
  logic        rs_valid = 1'b0, rs_taken = 1'b0;
  logic [31:0] rs_pc = '0, rs_target = '0;
  logic        lk_ready, pr_valid, pr_taken, pr_hit, pr_link_wr, rs_ready, rd_valid;
  logic [31:0] pr_target, pr_alt, pr_link_addr, rd_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // captured results
  logic        o_taken, o_hit, o_lw;
  logic [31:0] o_tgt, o_alt, o_la;
  logic        r_rdv;
  logic [31:0] r_rda;

  always #2.5 clk = ~clk;

  btc_predictor #(.IDX_W(IDX_W), .OFS_W(24), .PEND_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc), .lk_offset(lk_offset), .lk_link(lk_link),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_taken(pr_taken), .pr_hit(pr_hit),
    .pr_target(pr_target), .pr_alt(pr_alt), .pr_link_wr(pr_link_wr), .pr_link_addr(pr_link_addr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target),
    .rd_valid(rd_valid), .rd_addr(rd_addr)
  );

  function automatic logic [31:0] exp_tgt(input logic [31:0] pc, input logic [23:0] off);
    logic [31:0] d;
    d = {{6{off[23]}}, off, 2'b00};
    return pc + 32'd8 + d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input logic [23:0] off, input logic lnk);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; lk_offset = off; lk_link = lnk;
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
    o_taken = pr_taken; o_hit = pr_hit; o_tgt = pr_target;
    o_alt = pr_alt; o_lw = pr_link_wr; o_la = pr_link_addr;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = tk; rs_target = tgt;
    @(posedge clk);
    #1;
    rs_valid = 1'b0;
    r_rdv = rd_valid; r_rda = rd_addr;
  endtask

  task automatic t_reset();
    chk("R1 pr_valid", {31'd0, pr_valid}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 rs_ready", {31'd0, rs_ready}, 32'd0);
    chk("R1 lk_ready", {31'd0, lk_ready}, 32'd1);
  endtask

  task automatic t_idle_resolve();
    // R10: resolve with nothing pending has no effect
    resolve(32'h7000, 1'b1, 32'h7400);
    chk("R10 no redirect", {31'd0, r_rdv}, 32'd0);
    lookup(32'h7000, 24'h000010, 1'b0);
    chk("R10 no alloc", {31'd0, o_hit}, 32'd0);
    chk("R1 miss first", {31'd0, o_hit}, 32'd0);
    resolve(32'h7000, 1'b0, 32'h0);
    chk("R8 match no redirect", {31'd0, r_rdv}, 32'd0);
  endtask

  task automatic t_static();
    lookup(32'h1000, 24'hFFFFFC, 1'b1);
    chk("R2 backward taken", {31'd0, o_taken}, 32'd1);
    chk("R3 back target", o_tgt, exp_tgt(32'h1000, 24'hFFFFFC));
    chk("R3 link addr", o_la, 32'h1004);
    chk("R3 link wr", {31'd0, o_lw}, 32'd1);
    chk("R4 alt taken", o_alt, 32'h1004);
    resolve(32'h1000, 1'b1, 32'h0FF8);
    chk("R8 correct no redirect", {31'd0, r_rdv}, 32'd0);
    lookup(32'h1000, 24'hFFFFFC, 1'b0);
    chk("R5 alloc hit", {31'd0, o_hit}, 32'd1);
    chk("R5 alloc taken", {31'd0, o_taken}, 32'd1);
    chk("R5 alloc target", o_tgt, 32'h0FF8);
    resolve(32'h1000, 1'b1, 32'h0FF8);

    lookup(32'h2000, 24'h000010, 1'b0);
    chk("R2 forward not taken", {31'd0, o_taken}, 32'd0);
    chk("R4 alt not taken", o_alt, exp_tgt(32'h2000, 24'h000010));
    chk("R3 link wr off", {31'd0, o_lw}, 32'd0);
    resolve(32'h2000, 1'b1, 32'h2048);
    chk("R8 redirect valid", {31'd0, r_rdv}, 32'd1);
    chk("R8 redirect addr", r_rda, 32'h2048);

    lookup(32'h3000, 24'h000005, 1'b0);
    resolve(32'h3000, 1'b0, 32'h0);
    lookup(32'h3000, 24'h000005, 1'b0);
    chk("R5 not taken no alloc", {31'd0, o_hit}, 32'd0);
    resolve(32'h3000, 1'b0, 32'h0);
  endtask

  task automatic t_reach();
    lookup(32'h0400_0000, 24'h7FFFFF, 1'b0);
    chk("R3 max forward", o_tgt, 32'h0600_0004);
    resolve(32'h0400_0000, 1'b0, 32'h0);
    lookup(32'h0400_0100, 24'h800000, 1'b0);
    chk("R3 max backward", o_tgt, 32'h0200_0108);
    chk("R2 min offset taken", {31'd0, o_taken}, 32'd1);
    resolve(32'h0400_0100, 1'b1, 32'h0200_0108);
  endtask

  task automatic t_counter();
    logic [1:0] m;
    logic       p;
    logic       seq [9];
    seq = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    lookup(32'h5000, 24'h000010, 1'b0);
    resolve(32'h5000, 1'b1, 32'h5100);
    chk("R8 alloc redirect", {31'd0, r_rdv}, 32'd1);
    m = 2'd2;
    for (int i = 0; i < 9; i++) begin
      lookup(32'h5000, 24'h000010, 1'b0);
      p = m[1];
      chk("R6 hit", {31'd0, o_hit}, 32'd1);
      chk("R6 direction", {31'd0, o_taken}, {31'd0, p});
      chk("R6 target", o_tgt, 32'h5100);
      resolve(32'h5000, seq[i], 32'h5100);
      chk("R8 redirect on mismatch", {31'd0, r_rdv}, {31'd0, (seq[i] != p)});
      if (seq[i]) m = (m == 2'd3) ? m : m + 2'd1;
      else        m = (m == 2'd0) ? m : m - 2'd1;
    end
  endtask

  task automatic t_conflict();
    // R7: 0x6010 and 0x6050 share index 4
    lookup(32'h6010, 24'hFFFFF0, 1'b0);
    resolve(32'h6010, 1'b1, 32'h5FD8);
    lookup(32'h6050, 24'h000020, 1'b0);
    chk("R7 other tag misses", {31'd0, o_hit}, 32'd0);
    resolve(32'h6050, 1'b0, 32'h0);
    lookup(32'h6010, 24'hFFFFF0, 1'b0);
    chk("R7 not taken keeps entry", {31'd0, o_hit}, 32'd1);
    resolve(32'h6010, 1'b1, 32'h5FD8);
    lookup(32'h6050, 24'h000020, 1'b0);
    resolve(32'h6050, 1'b1, 32'h60D8);
    lookup(32'h6010, 24'hFFFFF0, 1'b0);
    chk("R7 replaced misses", {31'd0, o_hit}, 32'd0);
    resolve(32'h6010, 1'b1, 32'h5FD8);
    lookup(32'h6010, 24'hFFFFF0, 1'b0);
    resolve(32'h6010, 1'b1, 32'h5FD8);
  endtask

  task automatic t_stall();
    logic [31:0] held;
    pr_ready = 1'b0;
    lookup(32'h7100, 24'h000030, 1'b0);
    held = pr_target;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R9 valid held", {31'd0, pr_valid}, 32'd1);
    chk("R9 target held", pr_target, held);
    chk("R9 lk_ready low", {31'd0, lk_ready}, 32'd0);
    @(negedge clk);
    pr_ready = 1'b1;
    @(posedge clk); #1;
    chk("R9 drained", {31'd0, pr_valid}, 32'd0);
    resolve(32'h7100, 1'b0, 32'h0);
    chk("R9 resolve ok", {31'd0, r_rdv}, 32'd0);
  endtask

  task automatic t_queue();
    logic [31:0] alt1;
    lookup(32'h8000, 24'h000040, 1'b0);
    alt1 = o_alt;
    chk("R4 queue alt1", alt1, exp_tgt(32'h8000, 24'h000040));
    lookup(32'h8100, 24'hFFFF00, 1'b0);
    chk("R11 full stalls", {31'd0, lk_ready}, 32'd0);
    chk("R10 ready pending", {31'd0, rs_ready}, 32'd1);
    resolve(32'h8000, 1'b1, alt1);
    chk("R10 order first", r_rda, alt1);
    chk("R8 first redirect", {31'd0, r_rdv}, 32'd1);
    resolve(32'h8100, 1'b0, 32'h0);
    chk("R10 order second", r_rda, 32'h8104);
    chk("R8 second redirect", {31'd0, r_rdv}, 32'd1);
    chk("R10 drained", {31'd0, rs_ready}, 32'd0);
  endtask

  initial begin
    #50000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_idle_resolve();
    t_static();
    t_reach();
    t_counter();
    t_conflict();
    t_stall();
    t_queue();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule